// File: doc/BRIEF.md
# Dispatch Group Former

This block sits between decode and issue. It takes decoded instructions one per handshake, in program order, and packs them into dispatch groups. A group has six slots. Slots 0 to 3 take non-branch instructions and slots 4 and 5 take branches. When a group is complete, it is presented downstream as a slot-occupancy mask plus one payload field per slot. The block never reorders instructions.

Each instruction carries a branch flag and a two-bit placement code. Branches fill slots 4 and 5 in arrival order. The first branch leaves the group open, and the second branch closes it. Non-branch instructions fill slots 0 to 3 from the lowest free slot. Some need a leading position, so they are only placed into a group with no non-branch occupant yet. If such an instruction, or any other, does not fit, the open group is sent as it stands and the instruction starts the next group. A group is also sent when the input has a cycle without a valid instruction.

Internally there is an accumulator with two named states. In `ACC_EMPTY` no slot is filled. In `ACC_PART` at least one slot is filled. The transitions are:

- *fill*: EMPTY to PART, when an instruction is accepted and does not close the group.
- *close*: PART to EMPTY, when the second branch is accepted.
- *dry*: PART to EMPTY, when there is no valid input and the group is sent.
- *spill*: PART to PART, when a misfit sends the old group and seeds a new one.
- *grow*: PART to PART, when an instruction fits and does not close the group.

A single output register holds the group that was sent until downstream accepts it.

Top module: `dispatch_group_former`

## Requirements
- R1: After reset, `grp_valid` is 0, `grp_mask` is 0 and `in_ready` is 1.
- R2: A non-branch instruction with placement code 0 (any slot) takes the lowest free slot among 0 to 3. At most four non-branch slots are filled per group, and filled non-branch slots are always contiguous from slot 0.
- R3: Branches take slot 4 and then slot 5, in arrival order. A group holding one branch stays open to later instructions.
- R4: Accepting a second branch closes the group, and that branch is its last instruction.
- R5: Placement code 1 (lead slot) puts the instruction in slot 0 only. It is placed only when the group has no non-branch occupant; otherwise the open group is sent first.
- R6: Placement code 2 (lead pair) takes slots 0 and 1 together, with its payload copied into both. Later code-0 instructions continue at slot 2.
- R7: Placement code 3 (whole half) takes slots 0 to 3, with its payload in each. After it, no further non-branch instruction fits.
- R8: When the offered instruction does not fit, the open group is sent unchanged, and the instruction becomes the first member of the next group. Instruction order is kept.
- R9: In a cycle with no valid input, a partly filled group is sent. An empty group is never sent, and no group is presented while nothing has been accumulated.
- R10: While `grp_valid` is 1 and `grp_ready` is 0, the presented group stays stable and `in_ready` is 0, so no input is taken.
- R11: A group closed by an instruction accepted at a clock edge is presented immediately after that edge.
- R12: In `grp_mask`, bit i flags slot i, and the payload of slot i is `grp_slots[i*PW +: PW]`. An empty slot carries zero payload.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | An instruction is offered |
| in_ready | output | 1 | The offered instruction is taken this cycle |
| in_is_br | input | 1 | The offered instruction is a branch |
| in_need | input | 2 | Placement code: 0 any, 1 lead slot, 2 lead pair, 3 whole half |
| in_payload | input | PW | Instruction contents |
| grp_valid | output | 1 | A group is presented |
| grp_ready | input | 1 | Downstream takes the presented group |
| grp_mask | output | NB_SLOTS+BR_SLOTS | Slot occupancy |
| grp_slots | output | (NB_SLOTS+BR_SLOTS)*PW | Per-slot payloads, slot 0 in the low bits |

## Verification
Directed streams each isolate one rule:

- Two plain instructions followed by a gap separate a dry close from a fill.
- A branch, then a plain instruction, then a branch shows that the first branch leaves the group open and the second closes it.
- A plain instruction followed by a lead-slot instruction, and a whole-half instruction followed by a plain one, force spills.
- Five plain instructions in a row check the four-slot limit.
- Three branches in a row check the branch-slot limit.

A long random stream then mixes gaps, downstream stalls and all placement codes. It is compared group by group against a transaction model in the bench. That comparison catches wrong slot positions, lost or duplicated instructions, and groups cut at the wrong point under backpressure.

// File: rtl/dgf_pkg.sv
package dgf_pkg;

    typedef enum logic [1:0] {
        NEED_ANY  = 2'd0,
        NEED_LEAD = 2'd1,
        NEED_PAIR = 2'd2,
        NEED_HALF = 2'd3
    } need_e;

    typedef enum logic {
        ACC_EMPTY = 1'b0,
        ACC_PART  = 1'b1
    } acc_state_e;

endpackage

// File: rtl/dgf_fit.sv
module dgf_fit
    import dgf_pkg::*;
#(
    parameter int NB_SLOTS = 4,
    parameter int BR_SLOTS = 2,
    localparam int SLOTS = NB_SLOTS + BR_SLOTS,
    localparam int CW_NB = $clog2(NB_SLOTS + 1),
    localparam int CW_BR = $clog2(BR_SLOTS + 1),
    localparam int IW    = $clog2(SLOTS)
) (
    input  logic [CW_NB-1:0] nb_used,
    input  logic [CW_BR-1:0] br_used,
    input  logic             is_br,
    input  need_e            need,
    output logic             fits,
    output logic             closes,
    output logic [SLOTS-1:0] take_mask,
    output logic [CW_NB-1:0] nb_next,
    output logic [CW_BR-1:0] br_next
);

    logic [IW-1:0] br_idx;
    logic [IW-1:0] nb_idx;

    assign br_idx = IW'(NB_SLOTS) + IW'(br_used);
    assign nb_idx = IW'(nb_used);

    always_comb begin
        fits      = 1'b0;
        closes    = 1'b0;
        take_mask = '0;
        nb_next   = nb_used;
        br_next   = br_used;
        if (is_br) begin
            fits = (br_used < CW_BR'(BR_SLOTS));
            if (fits) begin
                take_mask[br_idx] = 1'b1;
                br_next           = br_used + CW_BR'(1);
                closes            = (br_next == CW_BR'(BR_SLOTS));
            end
        end else begin
            unique case (need)
                NEED_ANY: begin
                    fits = (nb_used < CW_NB'(NB_SLOTS));
                    if (fits) begin
                        take_mask[nb_idx] = 1'b1;
                        nb_next           = nb_used + CW_NB'(1);
                    end
                end
                NEED_LEAD: begin
                    fits = (nb_used == '0);
                    if (fits) begin
                        take_mask[0] = 1'b1;
                        nb_next      = CW_NB'(1);
                    end
                end
                NEED_PAIR: begin
                    fits = (nb_used == '0);
                    if (fits) begin
                        take_mask[1:0] = 2'b11;
                        nb_next        = CW_NB'(2);
                    end
                end
                NEED_HALF: begin
                    fits = (nb_used == '0);
                    if (fits) begin
                        take_mask[NB_SLOTS-1:0] = '1;
                        nb_next                 = CW_NB'(NB_SLOTS);
                    end
                end
                default: fits = 1'b0;
            endcase
        end
    end

endmodule

// File: rtl/dgf_out.sv
module dgf_out #(
    parameter int SLOTS = 6,
    parameter int PW    = 16,
    localparam int SW   = SLOTS * PW
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [SLOTS-1:0] ld_mask,
    input  logic [SW-1:0]    ld_slots,
    input  logic             grp_ready,
    output logic             free,
    output logic             grp_valid,
    output logic [SLOTS-1:0] grp_mask,
    output logic [SW-1:0]    grp_slots
);

    assign free = !grp_valid || grp_ready;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            grp_valid <= 1'b0;
            grp_mask  <= '0;
            grp_slots <= '0;
        end else if (free) begin
            grp_valid <= load;
            grp_mask  <= load ? ld_mask : '0;
            grp_slots <= load ? ld_slots : '0;
        end
    end

endmodule

// File: rtl/dispatch_group_former.sv
module dispatch_group_former
    import dgf_pkg::*;
#(
    parameter int NB_SLOTS = 4,
    parameter int BR_SLOTS = 2,
    parameter int PW       = 16,
    localparam int SLOTS = NB_SLOTS + BR_SLOTS,
    localparam int SW    = SLOTS * PW,
    localparam int CW_NB = $clog2(NB_SLOTS + 1),
    localparam int CW_BR = $clog2(BR_SLOTS + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic             in_is_br,
    input  logic [1:0]       in_need,
    input  logic [PW-1:0]    in_payload,
    output logic             grp_valid,
    input  logic             grp_ready,
    output logic [SLOTS-1:0] grp_mask,
    output logic [SW-1:0]    grp_slots
);

    acc_state_e       st_q, st_d;
    logic [CW_NB-1:0] nb_q, nb_d;
    logic [CW_BR-1:0] br_q, br_d;
    logic [SLOTS-1:0] mask_q, mask_d;
    logic [SW-1:0]    slots_q, slots_d;

    logic             load;
    logic [SLOTS-1:0] ld_mask;
    logic [SW-1:0]    ld_slots;
    logic             free;

    // placement into the open group and into a fresh group
    logic             a_fits, a_close, n_fits, n_close;
    logic [SLOTS-1:0] a_take, n_take;
    logic [CW_NB-1:0] a_nb, n_nb;
    logic [CW_BR-1:0] a_br, n_br;
    logic [SW-1:0]    a_fill, n_fill;

    dgf_fit #(.NB_SLOTS(NB_SLOTS), .BR_SLOTS(BR_SLOTS)) u_fit_acc (
        .nb_used(nb_q), .br_used(br_q), .is_br(in_is_br), .need(need_e'(in_need)),
        .fits(a_fits), .closes(a_close), .take_mask(a_take),
        .nb_next(a_nb), .br_next(a_br)
    );

    dgf_fit #(.NB_SLOTS(NB_SLOTS), .BR_SLOTS(BR_SLOTS)) u_fit_new (
        .nb_used('0), .br_used('0), .is_br(in_is_br), .need(need_e'(in_need)),
        .fits(n_fits), .closes(n_close), .take_mask(n_take),
        .nb_next(n_nb), .br_next(n_br)
    );

    dgf_out #(.SLOTS(SLOTS), .PW(PW)) u_out (
        .clk(clk), .rst_n(rst_n), .load(load), .ld_mask(ld_mask),
        .ld_slots(ld_slots), .grp_ready(grp_ready), .free(free),
        .grp_valid(grp_valid), .grp_mask(grp_mask), .grp_slots(grp_slots)
    );

    generate
        for (genvar i = 0; i < SLOTS; i++) begin : g_fill
            assign a_fill[i*PW +: PW] = a_take[i] ? in_payload : slots_q[i*PW +: PW];
            assign n_fill[i*PW +: PW] = n_take[i] ? in_payload : '0;
        end
    endgenerate

    assign in_ready = free;

    always_comb begin
        st_d     = st_q;
        nb_d     = nb_q;
        br_d     = br_q;
        mask_d   = mask_q;
        slots_d  = slots_q;
        load     = 1'b0;
        ld_mask  = '0;
        ld_slots = '0;
        if (free) begin
            unique case (st_q)
                ACC_EMPTY: begin
                    if (in_valid && n_fits) begin
                        if (n_close) begin
                            load     = 1'b1;
                            ld_mask  = n_take;
                            ld_slots = n_fill;
                        end else begin
                            st_d    = ACC_PART;
                            nb_d    = n_nb;
                            br_d    = n_br;
                            mask_d  = n_take;
                            slots_d = n_fill;
                        end
                    end
                end
                ACC_PART: begin
                    if (!in_valid) begin
                        load     = 1'b1;
                        ld_mask  = mask_q;
                        ld_slots = slots_q;
                        st_d     = ACC_EMPTY;
                        nb_d     = '0;
                        br_d     = '0;
                        mask_d   = '0;
                        slots_d  = '0;
                    end else if (a_fits) begin
                        if (a_close) begin
                            load     = 1'b1;
                            ld_mask  = mask_q | a_take;
                            ld_slots = a_fill;
                            st_d     = ACC_EMPTY;
                            nb_d     = '0;
                            br_d     = '0;
                            mask_d   = '0;
                            slots_d  = '0;
                        end else begin
                            nb_d    = a_nb;
                            br_d    = a_br;
                            mask_d  = mask_q | a_take;
                            slots_d = a_fill;
                        end
                    end else begin
                        load     = 1'b1;
                        ld_mask  = mask_q;
                        ld_slots = slots_q;
                        st_d     = n_close ? ACC_EMPTY : ACC_PART;
                        nb_d     = n_close ? '0 : n_nb;
                        br_d     = n_close ? '0 : n_br;
                        mask_d   = n_close ? '0 : n_take;
                        slots_d  = n_close ? '0 : n_fill;
                    end
                end
                default: st_d = ACC_EMPTY;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q    <= ACC_EMPTY;
            nb_q    <= '0;
            br_q    <= '0;
            mask_q  <= '0;
            slots_q <= '0;
        end else begin
            st_q    <= st_d;
            nb_q    <= nb_d;
            br_q    <= br_d;
            mask_q  <= mask_d;
            slots_q <= slots_d;
        end
    end

endmodule

// File: rtl/dgf_checker.sv
module dgf_checker #(
    parameter int NB_SLOTS = 4,
    parameter int BR_SLOTS = 2,
    parameter int PW       = 16,
    localparam int SLOTS = NB_SLOTS + BR_SLOTS,
    localparam int SW    = SLOTS * PW
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_ready,
    input logic             grp_valid,
    input logic             grp_ready,
    input logic [SLOTS-1:0] grp_mask,
    input logic [SW-1:0]    grp_slots
);

    assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (grp_valid && !grp_ready) |=> (grp_valid && $stable(grp_mask) && $stable(grp_slots)));

    assert_no_take_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (grp_valid && !grp_ready) |-> !in_ready);

    assert_nonempty_R9: assert property (@(posedge clk) disable iff (!rst_n)
        grp_valid |-> (grp_mask != '0));

    generate
        for (genvar k = 0; k < NB_SLOTS - 1; k++) begin : g_nb
            assert_nb_packed_R2: assert property (@(posedge clk) disable iff (!rst_n)
                (grp_valid && grp_mask[k+1]) |-> grp_mask[k]);
        end
        for (genvar k = 0; k < BR_SLOTS - 1; k++) begin : g_br
            assert_br_order_R3: assert property (@(posedge clk) disable iff (!rst_n)
                (grp_valid && grp_mask[NB_SLOTS+k+1]) |-> grp_mask[NB_SLOTS+k]);
        end
    endgenerate

endmodule

bind dispatch_group_former dgf_checker #(
    .NB_SLOTS(NB_SLOTS), .BR_SLOTS(BR_SLOTS), .PW(PW)
) u_chk (
    .clk(clk), .rst_n(rst_n), .in_ready(in_ready), .grp_valid(grp_valid),
    .grp_ready(grp_ready), .grp_mask(grp_mask), .grp_slots(grp_slots)
);

// File: tb/sim_dispatch_group_former.sv
`timescale 1ns/1ps
module sim_dispatch_group_former;

    localparam int PW = 16;
    localparam int SL = 6;
    localparam int SW = SL * PW;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0;
    logic in_is_br = 1'b0;
    logic [1:0] in_need = 2'd0;
    logic [PW-1:0] in_payload = '0;
    logic grp_ready = 1'b0;
    logic in_ready, grp_valid;
    logic [SL-1:0] grp_mask;
    logic [SW-1:0] grp_slots;

    always #2 clk = ~clk;

    dispatch_group_former #(.NB_SLOTS(4), .BR_SLOTS(2), .PW(PW)) u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_is_br(in_is_br), .in_need(in_need), .in_payload(in_payload),
        .grp_valid(grp_valid), .grp_ready(grp_ready),
        .grp_mask(grp_mask), .grp_slots(grp_slots)
    );

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    // transaction model
    int m_nb = 0, m_br = 0;
    logic [SL-1:0] m_mask = '0;
    logic [SW-1:0] m_slots = '0;
    logic [SL-1:0] q_mask[$];
    logic [SW-1:0] q_slots[$];
    string q_tag[$];
    logic [SL-1:0] obs_mask[$];
    logic [SW-1:0] obs_slots[$];

    logic s_v;
    logic [SL-1:0] s_mask, p_mask;
    logic [SW-1:0] s_slots, p_slots;
    bit held = 0;

    task automatic chk(bit ok, string tag, logic [SW-1:0] act, logic [SW-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic bit bfit(int nb, int br, bit isb, int need);
        if (isb) return br < 2;
        if (need == 0) return nb < 4;
        return nb == 0;
    endfunction

    task automatic m_push(string tag);
        q_mask.push_back(m_mask);
        q_slots.push_back(m_slots);
        q_tag.push_back(tag);
        m_nb = 0; m_br = 0; m_mask = '0; m_slots = '0;
    endtask

    task automatic m_place(bit isb, int need, logic [PW-1:0] p);
        if (isb) begin
            m_mask[4+m_br] = 1'b1;
            m_slots[(4+m_br)*PW +: PW] = p;
            m_br++;
        end else begin
            case (need)
                0: begin m_mask[m_nb] = 1'b1; m_slots[m_nb*PW +: PW] = p; m_nb++; end
                1: begin m_mask[0] = 1'b1; m_slots[0 +: PW] = p; m_nb = 1; end
                2: begin for (int i = 0; i < 2; i++) begin m_mask[i] = 1'b1; m_slots[i*PW +: PW] = p; end m_nb = 2; end
                default: begin for (int i = 0; i < 4; i++) begin m_mask[i] = 1'b1; m_slots[i*PW +: PW] = p; end m_nb = 4; end
            endcase
        end
    endtask

    task automatic model_step(bit v, bit isb, int need, logic [PW-1:0] p);
        if (!v) begin
            if (m_nb + m_br > 0) m_push("R9");
            return;
        end
        if (!bfit(m_nb, m_br, isb, need)) m_push("R8");
        m_place(isb, need, p);
        if (isb && m_br == 2) m_push("R4");
    endtask

    task automatic cycle(bit v, bit isb, int need, logic [PW-1:0] p, bit r);
        bit fr;
        @(negedge clk);
        s_v = grp_valid; s_mask = grp_mask; s_slots = grp_slots;
        if (held) begin
            chk(s_v && s_mask == p_mask && s_slots == p_slots, "R10 hold", s_slots, p_slots);
        end
        in_valid = v; in_is_br = isb; in_need = 2'(need); in_payload = p; grp_ready = r;
        #1;
        fr = !s_v || r;
        chk(in_ready == fr, "R10 in_ready", SW'(in_ready), SW'(fr));
        if (s_v && r) begin
            if (q_mask.size() == 0) begin
                chk(0, "R9 unexpected group", SW'(s_mask), '0);
            end else begin
                string t;
                logic [SL-1:0] em;
                logic [SW-1:0] es;
                em = q_mask.pop_front(); es = q_slots.pop_front(); t = q_tag.pop_front();
                chk(s_mask == em, {t, " R12 mask"}, SW'(s_mask), SW'(em));
                chk(s_slots == es, {t, " R12 slots"}, s_slots, es);
            end
            obs_mask.push_back(s_mask);
            obs_slots.push_back(s_slots);
        end
        held = s_v && !r;
        p_mask = s_mask; p_slots = s_slots;
        if (fr) model_step(v, isb, need, p);
    endtask

    task automatic drain();
        for (int i = 0; i < 4; i++) cycle(0, 0, 0, '0, 1);
    endtask

    task automatic obs_chk(int idx, logic [SL-1:0] exp, string tag);
        if (idx < obs_mask.size()) chk(obs_mask[idx] == exp, tag, SW'(obs_mask[idx]), SW'(exp));
        else chk(0, {tag, " missing group"}, '0, SW'(exp));
    endtask

    initial begin
        #400000;
        if (!finished) begin
            errors++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        bit pv, pb;
        int pn;
        logic [PW-1:0] pp;
        void'($urandom(32'h5eed_0042));
        repeat (3) @(negedge clk);
        #1;
        chk(grp_valid == 0 && grp_mask == 0 && in_ready == 1, "R1 reset",
            SW'({grp_valid, grp_mask, in_ready}), SW'(1));
        rst_n = 1'b1;

        // R2 R9: two plain then a gap
        obs_mask.delete(); obs_slots.delete();
        cycle(1, 0, 0, 16'h0a01, 1); cycle(1, 0, 0, 16'h0a02, 1); drain();
        obs_chk(0, 6'h03, "R2 R9 two plain");
        chk(obs_mask.size() == 1, "R9 one group only", SW'(obs_mask.size()), SW'(1));

        // R3 R4: branch, plain, branch closes
        obs_mask.delete(); obs_slots.delete();
        cycle(1, 1, 0, 16'h0b01, 1); cycle(1, 0, 0, 16'h0b02, 1); cycle(1, 1, 0, 16'h0b03, 1); drain();
        obs_chk(0, 6'h31, "R3 R4 branch close");
        if (obs_slots.size() > 0)
            chk(obs_slots[0][4*PW +: PW] == 16'h0b01 && obs_slots[0][5*PW +: PW] == 16'h0b03,
                "R3 branch order", obs_slots[0], '0);

        // R5: plain then lead-slot
        obs_mask.delete(); obs_slots.delete();
        cycle(1, 0, 0, 16'h0c01, 1); cycle(1, 0, 1, 16'h0c02, 1); drain();
        obs_chk(0, 6'h01, "R5 closed before lead");
        obs_chk(1, 6'h01, "R5 lead in slot0");

        // R6: pair then plain
        obs_mask.delete(); obs_slots.delete();
        cycle(1, 0, 2, 16'h0d01, 1); cycle(1, 0, 0, 16'h0d02, 1); drain();
        obs_chk(0, 6'h07, "R6 pair plus plain");
        if (obs_slots.size() > 0)
            chk(obs_slots[0][0 +: PW] == 16'h0d01 && obs_slots[0][PW +: PW] == 16'h0d01 &&
                obs_slots[0][2*PW +: PW] == 16'h0d02, "R6 pair payload", obs_slots[0], '0);

        // R7 R8: whole half then plain
        obs_mask.delete(); obs_slots.delete();
        cycle(1, 0, 3, 16'h0e01, 1); cycle(1, 0, 0, 16'h0e02, 1); drain();
        obs_chk(0, 6'h0f, "R7 whole half");
        obs_chk(1, 6'h01, "R8 spill after half");

        // R2 R8: five plain
        obs_mask.delete(); obs_slots.delete();
        for (int i = 0; i < 5; i++) cycle(1, 0, 0, PW'(16'h0f00 + i), 1);
        drain();
        obs_chk(0, 6'h0f, "R2 four limit");
        obs_chk(1, 6'h01, "R8 fifth spills");

        // R4 R11: three branches, closed group appears right after edge
        obs_mask.delete(); obs_slots.delete();
        cycle(1, 1, 0, 16'h1001, 1); cycle(1, 1, 0, 16'h1002, 1);
        cycle(1, 1, 0, 16'h1003, 1);
        chk(s_v == 1 && s_mask == 6'h30, "R11 latency", SW'({s_v, s_mask}), SW'({1'b1, 6'h30}));
        drain();
        obs_chk(0, 6'h30, "R4 two branches");
        obs_chk(1, 6'h10, "R4 third branch");

        // R10: stall with a group presented
        cycle(1, 0, 0, 16'h1101, 1);
        cycle(0, 0, 0, '0, 1);
        for (int i = 0; i < 3; i++) cycle(1, 0, 0, 16'h1102, 0);
        drain();

        // R9: idle emits nothing
        for (int i = 0; i < 3; i++) begin
            cycle(0, 0, 0, '0, 1);
            chk(s_v == 0, "R9 idle", SW'(s_v), '0);
        end

        // random phase, instruction held until taken
        pv = 0; pb = 0; pn = 0; pp = '0;
        for (int c = 0; c < 4000; c++) begin
            bit r;
            if (!pv || in_ready) begin
                pv = ($urandom % 4) != 0;
                pb = ($urandom % 4) == 0;
                pn = ($urandom % 3 == 0) ? int'($urandom % 4) : 0;
                pp = PW'($urandom);
            end
            r = ($urandom % 10) < 7;
            cycle(pv, pb, pn, pp, r);
        end
        pv = 0;
        for (int i = 0; i < 6; i++) cycle(0, 0, 0, '0, 1);
        chk(q_mask.size() == 0, "R9 all groups delivered", SW'(q_mask.size()), '0);

        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule